// File: doc/BRIEF.md
# Immediate-Operand Execution Slice

This block executes 32-bit instruction words whose second operand is a 16-bit constant carried in the word itself. Four operations are supported: placing the constant in the upper half of a register with the lower half cleared, a bitwise OR with a zero-extended constant, an addition with a sign-extended constant, and an addition with a zero-extended constant. Each operation reads one source register and writes one target register in a 32-entry, 32-bit register file.

One instruction completes on each rising clock edge at which the valid strobe is high. An upper-half load followed by an OR of the lower half into the same register builds any 32-bit constant exactly. This works because the OR never carries into, and never disturbs, the upper half that the first instruction placed.

A combinational debug port returns the contents of any register, so that software models and benches can observe the file without a separate read instruction. Register 0 is hard-wired to zero.

Top module: `imm_exec_unit`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers to zero.
- R2: Opcode 001111 (upper load) writes {imm, 16'h0000} to the target register. The source field is ignored and may hold any register number.
- R3: Opcode 001101 (OR) writes the source register ORed with the immediate zero-extended to 32 bits.
- R4: Opcode 001000 (signed add) writes the source register plus the immediate sign-extended to 32 bits. The sum wraps modulo 2^32 and no trap is raised.
- R5: Opcode 001001 (unsigned add) writes the source register plus the immediate zero-extended to 32 bits, wrapping modulo 2^32.
- R6: The instruction word is split as opcode in [31:26], source register in [25:21], target register in [20:16] and immediate in [15:0]. Register numbers are 5-bit unsigned values, so register 31 is 11111. The write happens on the rising edge at which valid is high, and the new value is visible on the debug port directly after that edge.
- R7: A write that targets register 0 is discarded, and register 0 always reads as zero, both as a source and on the debug port.
- R8: When valid is low, or the opcode is none of the four above, no register changes.
- R9: An upper load of the high half followed, on the next cycle, by an OR of the low half into the same register leaves exactly the intended 32-bit constant. This holds for any constant, including those with bit 15 or bit 31 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 32 | Instruction word |
| dbgAddr | input | 5 | Register number for the debug read |
| dbgData | output | 32 | Contents of the register selected by dbgAddr |

## Verification
The hardest case to reach from the ports is a chain in which one instruction consumes, on the very next cycle, the value that the previous instruction wrote. Examples are an OR into a register just loaded with its upper half, or a signed add of 1 onto an all-ones value built a cycle earlier. The stimulus issues these pairs back to back with no idle cycle between them. Constants with bit 15 set are chosen so that a wrong extension would corrupt the upper half. Garbage source fields are placed on the upper loads, and writes to register 0 are later read back as an operand, so that the ignored and discarded paths show up at the debug port.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 32;
  localparam int unsigned RIDX = $clog2(NREG);
  localparam int unsigned IMMW = 16;
  localparam int unsigned OPW  = 6;

  localparam int unsigned OP_LSB = XLEN - OPW;
  localparam int unsigned RS_LSB = OP_LSB - RIDX;
  localparam int unsigned RT_LSB = RS_LSB - RIDX;

  localparam logic [OPW-1:0] OPC_LUI  = 6'b001111;
  localparam logic [OPW-1:0] OPC_ORI  = 6'b001101;
  localparam logic [OPW-1:0] OPC_ADDI = 6'b001000;
  localparam logic [OPW-1:0] OPC_ADDU = 6'b001001;

  typedef enum logic [1:0] {
    EXT_ZERO  = 2'd0,
    EXT_SIGN  = 2'd1,
    EXT_UPPER = 2'd2
  } extKindT;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_OR   = 2'd1,
    ALU_ADD  = 2'd2
  } aluKindT;

  typedef struct packed {
    logic            wrEn;
    extKindT         extKind;
    aluKindT         aluKind;
    logic [RIDX-1:0] rsIdx;
    logic [RIDX-1:0] rtIdx;
    logic [IMMW-1:0] imm;
  } ctrlT;
endpackage

// File: rtl/imm_exec_ctrl.sv
module imm_exec_ctrl
  import imm_exec_pkg::*;
(
  input  logic            instrValid,
  input  logic [XLEN-1:0] instrWord,
  output ctrlT            ctl
);
  logic [OPW-1:0] opcode;

  assign opcode = instrWord[OP_LSB +: OPW];

  always_comb begin
    ctl.rsIdx   = instrWord[RS_LSB +: RIDX];
    ctl.rtIdx   = instrWord[RT_LSB +: RIDX];
    ctl.imm     = instrWord[IMMW-1:0];
    ctl.wrEn    = 1'b0;
    ctl.extKind = EXT_ZERO;
    ctl.aluKind = ALU_PASS;
    case (opcode)
      OPC_LUI: begin
        ctl.wrEn    = instrValid;
        ctl.extKind = EXT_UPPER;
        ctl.aluKind = ALU_PASS;
      end
      OPC_ORI: begin
        ctl.wrEn    = instrValid;
        ctl.extKind = EXT_ZERO;
        ctl.aluKind = ALU_OR;
      end
      OPC_ADDI: begin
        ctl.wrEn    = instrValid;
        ctl.extKind = EXT_SIGN;
        ctl.aluKind = ALU_ADD;
      end
      OPC_ADDU: begin
        ctl.wrEn    = instrValid;
        ctl.extKind = EXT_ZERO;
        ctl.aluKind = ALU_ADD;
      end
      default: ctl.wrEn = 1'b0;
    endcase
  end
endmodule

// File: rtl/imm_exec_dpath.sv
module imm_exec_dpath
  import imm_exec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  ctrlT            ctl,
  input  logic [RIDX-1:0] dbgAddr,
  output logic [XLEN-1:0] dbgData
);
  localparam int unsigned FILLW = XLEN - IMMW;

  logic [XLEN-1:0] regFile [NREG];
  logic [XLEN-1:0] rsVal;
  logic [XLEN-1:0] immExt;
  logic [XLEN-1:0] wrData;
  logic            doWrite;

  assign rsVal = regFile[ctl.rsIdx];

  always_comb begin
    case (ctl.extKind)
      EXT_SIGN:  immExt = {{FILLW{ctl.imm[IMMW-1]}}, ctl.imm};
      EXT_UPPER: immExt = {ctl.imm, {FILLW{1'b0}}};
      default:   immExt = {{FILLW{1'b0}}, ctl.imm};
    endcase
  end

  always_comb begin
    case (ctl.aluKind)
      ALU_OR:  wrData = rsVal | immExt;
      ALU_ADD: wrData = rsVal + immExt;
      default: wrData = immExt;
    endcase
  end

  assign doWrite = ctl.wrEn && (ctl.rtIdx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regFile[i] <= '0;
    end else if (doWrite) begin
      regFile[ctl.rtIdx] <= wrData;
    end
  end

  assign dbgData = regFile[dbgAddr];

  // R2: upper load places the immediate high and clears the low half
  a_r2_upper_fill: assert property (@(posedge clk) disable iff (rst)
    ctl.wrEn && ctl.extKind == EXT_UPPER |->
      wrData[IMMW-1:0] == '0 && wrData[XLEN-1:IMMW] == ctl.imm);

  // R3: an OR result keeps every bit already set in the source
  a_r3_or_keeps_src: assert property (@(posedge clk) disable iff (rst)
    ctl.wrEn && ctl.aluKind == ALU_OR |-> (wrData & rsVal) == rsVal);

  // R6: a committed write is in the file on the next cycle
  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
    ctl.wrEn && ctl.rtIdx != '0 |=>
      regFile[$past(ctl.rtIdx)] == $past(wrData));

  // R7: register 0 stays zero after a write aimed at it
  a_r7_zero_held: assert property (@(posedge clk) disable iff (rst)
    ctl.wrEn && ctl.rtIdx == '0 |=> regFile[0] == '0);

  // R8: no write strobe means the addressed target keeps its value
  a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
    !ctl.wrEn |=> regFile[$past(ctl.rtIdx)] == $past(regFile[ctl.rtIdx]));
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_exec_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instrValid,
  input  logic [31:0] instrWord,
  input  logic [4:0]  dbgAddr,
  output logic [31:0] dbgData
);
  ctrlT ctl;

  imm_exec_ctrl u_ctrl (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .ctl        (ctl)
  );

  imm_exec_dpath u_dpath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData)
  );
endmodule

// File: tb/sim_imm_exec_unit.sv
module sim_imm_exec_unit;
  localparam logic [5:0] LUI  = 6'b001111;
  localparam logic [5:0] ORI  = 6'b001101;
  localparam logic [5:0] ADDI = 6'b001000;
  localparam logic [5:0] ADDU = 6'b001001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic [4:0]  dbgAddr = '0;
  logic [31:0] dbgData;

  typedef struct {
    logic [4:0]  addr;
    logic [31:0] val;
    string       req;
  } chkT;

  chkT         sbq[$];
  logic [31:0] mdl [32];
  int          nVec = 0;
  int          nBad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  imm_exec_unit u0 (
    .clk        (clk),
    .rst        (rst),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .dbgAddr    (dbgAddr),
    .dbgData    (dbgData)
  );

  task automatic compare(input string req, input logic [4:0] a,
                         input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s reg %0d actual %h expected %h", req, a, got, exp);
    end
  endtask

  // driver: applies one instruction and queues the expected register value
  task automatic issue(input logic vld, input logic [5:0] op, input logic [4:0] rs,
                       input logic [4:0] rt, input logic [15:0] imm, input string req);
    logic [31:0] res;
    logic        wr;
    @(negedge clk);
    instrValid = vld;
    instrWord  = {op, rs, rt, imm};
    wr = vld;
    case (op)
      LUI:  res = {imm, 16'h0000};
      ORI:  res = mdl[rs] | {16'h0000, imm};
      ADDI: res = mdl[rs] + {{16{imm[15]}}, imm};
      ADDU: res = mdl[rs] + {16'h0000, imm};
      default: begin res = '0; wr = 1'b0; end
    endcase
    if (wr && rt != 5'd0) mdl[rt] = res;
    sbq.push_back('{addr: rt, val: mdl[rt], req: req});
  endtask

  task automatic idle();
    @(negedge clk);
    instrValid = 1'b0;
    instrWord  = '0;
  endtask

  // monitor: after each edge, pops the items that edge was meant to produce
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sbq.size() > 0) begin
        chkT it;
        it = sbq.pop_front();
        dbgAddr = it.addr;
        #0.5;
        compare(it.req, it.addr, dbgData, it.val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    rst = 1'b1;
    instrValid = 1'b1;
    instrWord = {LUI, 5'd0, 5'd9, 16'hBEEF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    instrValid = 1'b0;
    // R1: every register reads zero after reset
    for (int i = 0; i < 32; i++) begin
      dbgAddr = i[4:0];
      #0.5;
      compare("R1", i[4:0], dbgData, 32'h0);
    end

    // R2: upper load, garbage source field
    issue(1'b1, LUI, 5'd31, 5'd1, 16'h0123, "R2");
    // R9: back-to-back OR completes the constant
    issue(1'b1, ORI, 5'd1, 5'd1, 16'hABCD, "R9");
    issue(1'b1, LUI, 5'd1, 5'd5, 16'h8000, "R2");
    // R4: sign-extended add from zero register
    issue(1'b1, ADDI, 5'd0, 5'd2, 16'hFFFF, "R4");
    issue(1'b1, ADDI, 5'd1, 5'd3, 16'h8000, "R4");
    issue(1'b1, ADDI, 5'd1, 5'd3, 16'h7FFF, "R4");
    // R4: wrap to zero
    issue(1'b1, LUI, 5'd0, 5'd4, 16'hFFFF, "R2");
    issue(1'b1, ORI, 5'd4, 5'd4, 16'hFFFF, "R3");
    issue(1'b1, ADDI, 5'd4, 5'd4, 16'h0001, "R4");
    // R5: zero-extended add wraps
    issue(1'b1, ADDU, 5'd2, 5'd6, 16'h8000, "R5");
    issue(1'b1, ADDU, 5'd1, 5'd6, 16'hFFFF, "R5");
    // R3: OR with another source register
    issue(1'b1, ORI, 5'd3, 5'd7, 16'h00F0, "R3");
    issue(1'b1, ORI, 5'd5, 5'd8, 16'h8001, "R3");
    // R6: highest register number as both source and target
    issue(1'b1, LUI, 5'd7, 5'd31, 16'hC3A5, "R6");
    issue(1'b1, ADDI, 5'd31, 5'd31, 16'hFFFE, "R6");
    // R7: write to register 0 discarded, then used as source
    issue(1'b1, LUI, 5'd3, 5'd0, 16'hDEAD, "R7");
    issue(1'b1, ADDU, 5'd0, 5'd9, 16'h0005, "R7");
    issue(1'b1, ORI, 5'd0, 5'd0, 16'h1234, "R7");
    // R8: invalid strobe and unknown opcodes leave the target alone
    issue(1'b0, LUI, 5'd0, 5'd1, 16'h5555, "R8");
    issue(1'b1, 6'b000000, 5'd2, 5'd1, 16'h1111, "R8");
    issue(1'b1, 6'b100011, 5'd2, 5'd6, 16'h2222, "R8");
    issue(1'b1, 6'b001100, 5'd2, 5'd3, 16'hFFFF, "R8");
    issue(1'b0, ADDI, 5'd2, 5'd31, 16'h0001, "R8");
    // R9: constants with bit 15 and/or bit 31 set
    for (int k = 0; k < 12; k++) begin
      logic [31:0] c;
      logic [4:0]  r;
      c = 32'h8000_8000 ^ (32'h9E37_79B9 * (k + 1));
      r = 5'd10 + k[4:0];
      issue(1'b1, LUI, 5'd31 - r, r, c[31:16], "R9");
      issue(1'b1, ORI, r, r, c[15:0], "R9");
      if (mdl[r] !== c) begin
        nBad++;
        $display("FAIL R9 model mismatch actual %h expected %h", mdl[r], c);
      end
    end
    idle();
    idle();
    // final sweep of the whole file against the model
    for (int i = 0; i < 32; i++) begin
      dbgAddr = i[4:0];
      #0.5;
      compare("R6", i[4:0], dbgData, mdl[i]);
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule